// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block runs beside a DRAM controller and owns every refresh decision. After reset it waits out a power-up pause. It then asks the controller for a fixed burst of initialisation cycles. Once that burst is complete it raises `init_done` and starts a periodic schedule, so that every row is refreshed within the retention window. Each refresh uses the CAS-before-RAS ordering, so the device's internal row counter supplies the row and no address is driven. While a granted cycle runs, the block drives the RAS and CAS strobes itself. The controller only has to release the bus whenever `busy` is high.

Refreshes that fall due while the controller is occupied are recorded in a debt counter, up to a limit. When the debt reaches the limit, `ref_urgent` tells the controller to stop postponing. A self-refresh request extends a granted cycle into a long hold with both strobes low. Releasing the request ends the hold with a RAS-high recovery interval, after which the periodic schedule starts again from zero.

The FSM has seven states:

- **PAUSE**: the power-up wait.
- **IDLE**: the request point.
- **CAS_LEAD**: CAS is low and RAS is high.
- **RAS_LOW**: both strobes are low.
- **PRECHARGE**: both strobes are high.
- **SELF_HOLD**: the self-refresh hold.
- **SELF_EXIT**: the recovery interval after self-refresh.

The transitions are:

- PAUSE→IDLE when the pause expires.
- IDLE→CAS_LEAD when work is pending and `grant` is high.
- CAS_LEAD→RAS_LOW when the lead time expires.
- RAS_LOW→SELF_HOLD when `self_req` is high and `init_done` is set, otherwise RAS_LOW→PRECHARGE.
- PRECHARGE→IDLE when the precharge time expires.
- SELF_HOLD→SELF_EXIT once the minimum hold has elapsed and `self_req` is low.
- SELF_EXIT→IDLE when the recovery time expires.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and just after it, `ras_n` and `cas_n` are 1, and `ref_req`, `ref_urgent`, `busy`, `init_done` and `self_active` are 0.
- R2: After reset is released, `ref_req` first goes high PAUSE_CYC cycles later. No strobe moves before that point.
- R3: `init_done` rises when exactly INIT_CYCLES refresh cycles have completed. Until then `self_req` has no effect: every cycle keeps RAS low for only RAS_LOW_CYC cycles.
- R4: In every cycle, CAS goes low first, with RAS high, for CAS_LEAD_CYC cycles. RAS is never low while CAS is high.
- R5: Both strobes stay low for RAS_LOW_CYC cycles and then both stay high for PRECH_CYC cycles. Back-to-back cycles are separated by PRECH_CYC+1 cycles with both strobes high.
- R6: `ref_req` is high only in IDLE while work is pending. A `grant` that arrives with nothing pending moves no strobe.
- R7: Once `init_done` is set, the debt rises by one every REF_PERIOD cycles. The first increment makes `ref_req` visible REF_PERIOD cycles after `init_done` first reads 1.
- R8: `ref_urgent` is 1 exactly when the debt equals DEBT_LIMIT. Each completed refresh cycle retires one unit of debt, and `ref_req` drops when the debt reaches zero.
- R9: If `self_req` is high at the end of RAS_LOW, both strobes stay low and `self_active` is 1 for max(SELF_MIN_CYC, the time `self_req` stays high) cycles.
- R10: Leaving self-refresh holds both strobes high with `busy` set for SELF_EXIT_CYC cycles. It clears the debt and restarts the period, so the next `ref_req` comes REF_PERIOD cycles after `busy` falls.
- R11: `busy` is 1 whenever either strobe is low, and also during the PRECHARGE and SELF_EXIT states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant | input | 1 | Controller permits a refresh cycle to start |
| self_req | input | 1 | Request to enter, and stay in, self-refresh |
| ref_req | output | 1 | A refresh, initialisation or self-refresh entry cycle is pending |
| ref_urgent | output | 1 | The refresh debt has reached its limit |
| busy | output | 1 | The block owns the strobes |
| init_done | output | 1 | The initialisation burst is complete |
| self_active | output | 1 | Self-refresh hold in progress |
| ras_n | output | 1 | Row strobe drive, active low |
| cas_n | output | 1 | Column strobe drive, active low; one byte-lane strobe is enough |

## Verification
The assertions assume the controller does not leave the debt saturated while further periods elapse, so that the retire arithmetic never meets a lost increment. They also assume that a raised `self_req` stays high until `self_active` appears, or is lowered only after `init_done`. The directed stimulus meets both assumptions. It grants promptly once `ref_urgent` appears, and it changes `self_req` only on the falling clock edge at known points: during the initialisation burst (where it must be ignored), and in the self-refresh scenarios, where it is dropped either on the first hold cycle or after forty hold cycles. All measured lengths are derived from the parameters the bench passes in.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_CAS_LEAD,
        ST_RAS_LOW,
        ST_PRECHARGE,
        ST_SELF_HOLD,
        ST_SELF_EXIT
    } rfs_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rfs_phase_timer.sv
module rfs_phase_timer #(
    parameter int W         = 8,
    parameter int RESET_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= W'(RESET_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int PERIOD = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(PERIOD + 1);
    logic [TW-1:0] cnt;

    assign tick = en && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= TW'(PERIOD - 1);
        else if (!en)    cnt <= TW'(PERIOD - 1);
        else if (tick)   cnt <= TW'(PERIOD - 1);
        else             cnt <= cnt - TW'(1);
    end
endmodule

// File: rtl/rfs_debt_ledger.sv
module rfs_debt_ledger #(
    parameter int INIT_CYCLES = 8,
    parameter int DEBT_LIMIT  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cycle_done,
    input  logic self_done,
    output logic init_done,
    output logic owes,
    output logic urgent
);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam int DW = $clog2(DEBT_LIMIT + 1);

    logic [IW-1:0] init_left;
    logic [DW-1:0] debt;
    logic          retire;

    assign init_done = (init_left == '0);
    assign owes      = (debt != '0);
    assign urgent    = (debt == DW'(DEBT_LIMIT));
    assign retire    = cycle_done && init_done && owes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_left <= IW'(INIT_CYCLES);
            debt      <= '0;
        end else begin
            if (cycle_done && !init_done)
                init_left <= init_left - IW'(1);
            if (self_done)
                debt <= '0;
            else if (tick && !retire && !urgent)
                debt <= debt + DW'(1);
            else if (retire && !tick)
                debt <= debt - DW'(1);
        end
    end

    AST_INIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (init_left != $past(init_left)) |-> $past(cycle_done)); // R3
    AST_DEBT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !tick && !self_done) |=> (debt == $past(debt) - DW'(1))); // R8
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import rfs_pkg::*;
#(
    parameter int PAUSE_CYC     = 25000,
    parameter int INIT_CYCLES   = 8,
    parameter int REF_PERIOD    = 1950,
    parameter int CAS_LEAD_CYC  = 2,
    parameter int RAS_LOW_CYC   = 4,
    parameter int PRECH_CYC     = 3,
    parameter int DEBT_LIMIT    = 4,
    parameter int SELF_MIN_CYC  = 12600,
    parameter int SELF_EXIT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic self_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic busy,
    output logic init_done,
    output logic self_active,
    output logic ras_n,
    output logic cas_n
);
    localparam int PH_MAX = imax(imax(imax(PAUSE_CYC, SELF_MIN_CYC), imax(CAS_LEAD_CYC, RAS_LOW_CYC)),
                                 imax(imax(PRECH_CYC, SELF_EXIT_CYC), 1));
    localparam int PH_W   = $clog2(PH_MAX + 1);

    rfs_state_t      state, state_nx;
    logic            ph_load, ph_expired;
    logic [PH_W-1:0] ph_val;
    logic            tick, timer_en, cycle_done, self_done, owes, pending;

    // phase duration for the state being entered
    function automatic logic [PH_W-1:0] phase_len(input rfs_state_t s);
        unique case (s)
            ST_PAUSE:     return PH_W'(PAUSE_CYC - 1);
            ST_CAS_LEAD:  return PH_W'(CAS_LEAD_CYC - 1);
            ST_RAS_LOW:   return PH_W'(RAS_LOW_CYC - 1);
            ST_PRECHARGE: return PH_W'(PRECH_CYC - 1);
            ST_SELF_HOLD: return PH_W'(SELF_MIN_CYC - 1);
            ST_SELF_EXIT: return PH_W'(SELF_EXIT_CYC - 1);
            default:      return '0;
        endcase
    endfunction

    rfs_phase_timer #(.W(PH_W), .RESET_VAL(PAUSE_CYC - 1)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_expired)
    );

    rfs_interval_timer #(.PERIOD(REF_PERIOD)) u_period (
        .clk(clk), .rst_n(rst_n), .en(timer_en), .tick(tick)
    );

    rfs_debt_ledger #(.INIT_CYCLES(INIT_CYCLES), .DEBT_LIMIT(DEBT_LIMIT)) u_ledger (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cycle_done(cycle_done), .self_done(self_done),
        .init_done(init_done), .owes(owes), .urgent(ref_urgent)
    );

    assign pending    = !init_done || owes || (self_req && init_done);
    assign cycle_done = (state == ST_PRECHARGE) && ph_expired;
    assign self_done  = (state == ST_SELF_EXIT) && ph_expired;
    assign timer_en   = init_done && (state != ST_SELF_HOLD) && (state != ST_SELF_EXIT);
    assign ph_load    = (state_nx != state);
    assign ph_val     = phase_len(state_nx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PAUSE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PAUSE:     if (ph_expired) state_nx = ST_IDLE;
            ST_IDLE:      if (pending && grant) state_nx = ST_CAS_LEAD;
            ST_CAS_LEAD:  if (ph_expired) state_nx = ST_RAS_LOW;
            ST_RAS_LOW:   if (ph_expired)
                              state_nx = (self_req && init_done) ? ST_SELF_HOLD : ST_PRECHARGE;
            ST_PRECHARGE: if (ph_expired) state_nx = ST_IDLE;
            ST_SELF_HOLD: if (ph_expired && !self_req) state_nx = ST_SELF_EXIT;
            ST_SELF_EXIT: if (ph_expired) state_nx = ST_IDLE;
            default:      state_nx = ST_PAUSE;
        endcase
    end

    // outputs
    always_comb begin
        ras_n       = 1'b1;
        cas_n       = 1'b1;
        busy        = 1'b0;
        ref_req     = 1'b0;
        self_active = 1'b0;
        unique case (state)
            ST_PAUSE:     ;
            ST_IDLE:      ref_req = pending;
            ST_CAS_LEAD:  begin cas_n = 1'b0; busy = 1'b1; end
            ST_RAS_LOW:   begin cas_n = 1'b0; ras_n = 1'b0; busy = 1'b1; end
            ST_PRECHARGE: busy = 1'b1;
            ST_SELF_HOLD: begin cas_n = 1'b0; ras_n = 1'b0; busy = 1'b1; self_active = 1'b1; end
            ST_SELF_EXIT: busy = 1'b1;
            default:      ;
        endcase
    end

    // run of cycles with both strobes high, for the precharge spacing check
    logic [PH_W-1:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hi_cnt <= PH_W'(PRECH_CYC);
        else if (!(ras_n && cas_n)) hi_cnt <= '0;
        else if (hi_cnt < PH_W'(PRECH_CYC)) hi_cnt <= hi_cnt + PH_W'(1);
    end

    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R4
    AST_PRECH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (hi_cnt >= PH_W'(PRECH_CYC))); // R5
    AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !busy); // R6
    AST_SELF_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        self_active |-> init_done); // R3
    AST_SELF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(self_active) |-> !$past(self_req)); // R9
endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
    localparam int PAUSE = 30, INIT = 8, PERIOD = 60, LEAD = 2, RLOW = 3, PRE = 3,
                   LIMIT = 3, SMIN = 20, SEXIT = 4;

    logic clk = 1'b0, rst_n = 1'b0, grant = 1'b0, self_req = 1'b0;
    logic ref_req, ref_urgent, busy, init_done, self_active, ras_n, cas_n;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    refresh_sched #(
        .PAUSE_CYC(PAUSE), .INIT_CYCLES(INIT), .REF_PERIOD(PERIOD), .CAS_LEAD_CYC(LEAD),
        .RAS_LOW_CYC(RLOW), .PRECH_CYC(PRE), .DEBT_LIMIT(LIMIT), .SELF_MIN_CYC(SMIN),
        .SELF_EXIT_CYC(SEXIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .grant(grant), .self_req(self_req), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .busy(busy), .init_done(init_done), .self_active(self_active),
        .ras_n(ras_n), .cas_n(cas_n)
    );

    // strobe monitor, sampled on the falling edge
    int run_lead = 0, last_lead = 0, run_low = 0, last_low = 0, max_low = 0;
    int run_tail = 0, last_tail = 0, gap_run = 0, last_gap = 0;
    int cbr_cnt = 0, order_bad = 0, busy_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ras_n && cas_n) order_bad++;
            if ((!ras_n || !cas_n) && !busy) busy_bad++;
            if (ras_n && !cas_n) run_lead++;
            else begin if (run_lead != 0) last_lead = run_lead; run_lead = 0; end
            if (!ras_n && !cas_n) run_low++;
            else begin
                if (run_low != 0) begin
                    last_low = run_low;
                    if (run_low > max_low) max_low = run_low;
                    cbr_cnt++;
                end
                run_low = 0;
            end
            if (ras_n && cas_n && busy) run_tail++;
            else begin if (run_tail != 0) last_tail = run_tail; run_tail = 0; end
            if (ras_n && cas_n) gap_run++;
            else begin if (ras_n && !cas_n && gap_run != 0) last_gap = gap_run; gap_run = 0; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; grant = 1'b0; self_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 strobes idle", {30'd0, ras_n, cas_n}, 3);
        chk("R1 flags clear", {27'd0, ref_req, ref_urgent, busy, init_done, self_active}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_pause_init();
        int n = 0;
        grant = 1'b1; self_req = 1'b1;
        do begin @(negedge clk); n++; end while (!ref_req && n < 1000);
        chk("R2 pause length", n, PAUSE);
        chk("R2 no strobe before request", cbr_cnt + run_lead, 0);
        n = 0;
        while (!init_done && n < 2000) begin @(negedge clk); n++; end
        self_req = 1'b0; grant = 1'b0;
        @(negedge clk);
        chk("R3 init cycle count", cbr_cnt, INIT);
        chk("R3 self request ignored during init", max_low, RLOW);
        chk("R4 CAS lead length", last_lead, LEAD);
        chk("R4 no RAS low with CAS high", order_bad, 0);
        chk("R5 precharge length", last_tail, PRE);
        chk("R5 back-to-back gap", last_gap, PRE + 1);
        chk("R11 busy while driving", busy_bad, 0);
    endtask

    task automatic t_debt();
        int n = 1;
        int c0 = cbr_cnt;
        while (!ref_req && n < 1000) begin @(negedge clk); n++; end
        chk("R7 first period", n, PERIOD);
        while (!ref_urgent && n < 1000) begin @(negedge clk); n++; end
        chk("R8 urgent at limit", n, LIMIT * PERIOD);
        chk("R6 no cycle without grant", cbr_cnt - c0, 0);
        grant = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while ((ref_req || busy) && n < 1000);
        grant = 1'b0;
        @(negedge clk);
        chk("R8 debt retired by cycles", cbr_cnt - c0, LIMIT);
        chk("R8 urgent cleared", {31'd0, ref_urgent}, 0);
        chk("R5 gap under debt", last_gap, PRE + 1);
    endtask

    task automatic t_self_early();
        int n = 0;
        int c0;
        while (!ref_req && n < 1000) begin @(negedge clk); n++; end
        self_req = 1'b1; grant = 1'b1;
        n = 0;
        while (!self_active && n < 100) begin @(negedge clk); n++; end
        self_req = 1'b0;
        n = 0;
        while (busy && n < 1000) begin @(negedge clk); n++; end
        @(negedge clk);
        chk("R9 minimum self hold", last_low, RLOW + SMIN);
        chk("R10 exit recovery", last_tail, SEXIT);
        chk("R10 debt cleared", {31'd0, ref_req}, 0);
        c0 = cbr_cnt;
        n = 1;
        while (!ref_req && n < 1000) begin @(negedge clk); n++; end
        chk("R10 period restarted", n, PERIOD);
        chk("R6 grant ignored when idle", cbr_cnt - c0, 0);
    endtask

    task automatic t_self_long();
        int n = 0;
        int m = 1;
        int stayed = 1;
        do begin @(negedge clk); n++; end while ((ref_req || busy) && n < 1000);
        self_req = 1'b1;
        n = 0;
        while (!self_active && n < 100) begin @(negedge clk); n++; end
        while (m < 40) begin
            @(negedge clk); m++;
            if (!self_active) stayed = 0;
        end
        self_req = 1'b0; grant = 1'b0;
        n = 0;
        while (busy && n < 1000) begin @(negedge clk); n++; end
        @(negedge clk);
        chk("R9 hold follows request", stayed, 1);
        chk("R9 long self hold", last_low, RLOW + 40);
        chk("R10 exit recovery long", last_tail, SEXIT);
        chk("R4 order kept overall", order_bad, 0);
        chk("R11 busy overall", busy_bad, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pause_init();
        t_debt();
        t_self_early();
        t_self_long();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule